// File: doc/BRIEF.md
# Core Power Sequencer

This block controls power for a cluster of one to four processor cores and is driven over a simple 32-bit register bus. To bring a sleeping core up, software sets that core's bit in the wake register. The controller then turns the core's power on and keeps its reset held for a fixed number of cycles. After that it releases reset, marks the core as running and clears the wake bit. Software polls the wake register until it reads zero.

To put a core to sleep, software first arms it by writing a mode code into that core's control register. Nothing changes at the moment of the write. The core drops into standby only at its next wait-for-interrupt pulse. On entry the controller asserts the core's reset, removes its power and clears the armed code. A status register reports the state of each core. A debug reset-enable register keeps a small set of enable bits.

Top module: `core_power_seq`

## Requirements
- R1: After reset, core 0 is running: its `pwr_en` is 1, its `core_rst` is 0 and its status field is 0. Every other core is in standby: `pwr_en` 0, `core_rst` 1, status field 3. The wake register and the debug register read 0.
- R2: The wake register is at offset 0x10. Writing a 1 to bit n while core n is in standby starts its power-up. `pwr_en[n]` rises in the cycle after the write, and `core_rst[n]` stays 1 through the power-on phase.
- R3: The power-on phase lasts WAKE_CYCLES cycles. Then `core_rst[n]` is 0 for one cycle while the status is still 3. In the cycle after that the status field reads 0. Wake bit n reads 1 from the write until the status changes, and reads 0 after that.
- R4: The status register is at offset 0x40. Core n has a 2-bit field at bits 4n+1:4n, with 0 meaning run and 3 meaning standby. All other bits read 0.
- R5: Core n's control register is at offset 0x100 + 0x10·n. A write stores wdata[1:0] as the armed mode, and a read returns that mode in bits 1:0 with 0 in all other bits. Writes are stored whatever state the core is in.
- R6: If a running core has armed mode 3 and `wfi[n]` is high at a clock edge, the next cycle shows `core_rst[n]`=1, `pwr_en[n]`=0, status 3 and armed mode 0.
- R7: The `wfi[n]` input has no effect when the armed mode is not 3 or when the core is not running. Writing the armed mode by itself does not change any output.
- R8: A wake write to a core that is already running sets its wake bit for one cycle only and changes no output. A wake write during power-up has no effect. Wake bits for core numbers at or above NUM_CORES are ignored.
- R9: The debug register is at offset 0x180. Bits 24, 19 and 20+n (for n < NUM_CORES) are read/write. All other bits read 0. Offsets that are not decoded read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wfi | input | NUM_CORES | Per-core wait-for-interrupt |
| pwr_en | output | NUM_CORES | Per-core power enable |
| core_rst | output | NUM_CORES | Per-core reset, active high |

## Verification
The bench builds the block with NUM_CORES=4 and WAKE_CYCLES=5. With four cores, every status field and every per-core debug enable bit is used, and wake bits 4 and above are the ignored ones. The short wake time means a whole power-up, polled cycle by cycle, takes only a few cycles. That leaves room in the run to wake a core that is still powering up and to arm a core while it sleeps. A behavioural model predicts `pwr_en` and `core_rst` at every clock and the value of each register read.

// File: rtl/cps_pkg.sv
package cps_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_SLP  = 2'd1,
      ST_PWR  = 2'd2,
      ST_REL  = 2'd3
   } core_st_e;

   localparam int unsigned OFS_WAKE   = 32'h010;
   localparam int unsigned OFS_STAT   = 32'h040;
   localparam int unsigned OFS_CTL0   = 32'h100;
   localparam int unsigned CTL_STRIDE = 32'h010;
   localparam int unsigned OFS_DBG    = 32'h180;

   localparam logic [1:0] STAT_RUN  = 2'd0;
   localparam logic [1:0] STAT_SLP  = 2'd3;
   localparam logic [1:0] MODE_SLP  = 2'd3;
endpackage

// File: rtl/cps_core_seq.sv
module cps_core_seq
   import cps_pkg::*;
#(
   parameter int unsigned WAKE_CYCLES = 8,
   parameter bit          START_RUN   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wake_wr,
   input  logic       ctl_wr,
   input  logic [1:0] ctl_data,
   input  logic       wfi,
   output logic       pwr_en,
   output logic       core_rst,
   output logic       pend,
   output logic [1:0] armed,
   output logic [1:0] stat
);
   localparam int unsigned CNT_W = $clog2(WAKE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

   core_st_e         st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic [1:0]       armed_q;

   initial begin
      assert (WAKE_CYCLES >= 1) else $error("WAKE_CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= START_RUN ? ST_RUN : ST_SLP;
         cnt_q   <= '0;
         pend_q  <= 1'b0;
         armed_q <= 2'd0;
      end else begin
         unique case (st_q)
            ST_RUN: begin
               pend_q <= wake_wr;
               if (armed_q == MODE_SLP && wfi) begin
                  st_q    <= ST_SLP;
                  armed_q <= 2'd0;
               end else if (ctl_wr) begin
                  armed_q <= ctl_data;
               end
            end
            ST_SLP: begin
               if (ctl_wr) armed_q <= ctl_data;
               if (wake_wr) begin
                  st_q   <= ST_PWR;
                  cnt_q  <= '0;
                  pend_q <= 1'b1;
               end
            end
            ST_PWR: begin
               if (ctl_wr) armed_q <= ctl_data;
               if (cnt_q == CNT_LAST) st_q <= ST_REL;
               else cnt_q <= cnt_q + 1'b1;
            end
            ST_REL: begin
               if (ctl_wr) armed_q <= ctl_data;
               st_q   <= ST_RUN;
               pend_q <= 1'b0;
            end
            default: st_q <= ST_SLP;
         endcase
      end
   end

   assign pwr_en   = (st_q != ST_SLP);
   assign core_rst = (st_q == ST_SLP) || (st_q == ST_PWR);
   assign pend     = pend_q;
   assign armed    = armed_q;
   assign stat     = (st_q == ST_RUN) ? STAT_RUN : STAT_SLP;

   p_up_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SLP && wake_wr) |=> (pwr_en && core_rst && pend));

   p_no_rst_release_unpowered_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> core_rst);

   p_release_then_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |=> (stat == STAT_RUN));

   p_standby_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == STAT_RUN && armed == MODE_SLP && wfi)
      |=> (!pwr_en && core_rst && armed == 2'd0 && stat == STAT_SLP));

   p_wfi_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && armed != MODE_SLP) |=> pwr_en && !core_rst);
endmodule

// File: rtl/cps_dbg_reg.sv
module cps_dbg_reg #(
   parameter logic [31:0] WMASK = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata
);
   logic [31:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr) q <= wdata & WMASK;
   end

   assign rdata = q;

   p_dbg_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (rdata == (($past(wdata)) & WMASK)));
endmodule

// File: rtl/core_power_seq.sv
module core_power_seq
   import cps_pkg::*;
#(
   parameter int unsigned NUM_CORES   = 4,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned WAKE_CYCLES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_CORES-1:0] wfi,
   output logic [NUM_CORES-1:0] pwr_en,
   output logic [NUM_CORES-1:0] core_rst
);
   localparam logic [31:0] DBG_WMASK =
      (32'h1 << 24) | (32'h1 << 19) | (((32'h1 << NUM_CORES) - 32'h1) << 20);

   initial begin
      assert (NUM_CORES >= 1 && NUM_CORES <= 4) else $error("NUM_CORES must be 1..4");
      assert (ADDR_W >= 9 && ADDR_W <= 32) else $error("ADDR_W must cover offset 0x180");
   end

   logic                 wr_acc;
   logic                 wake_hit;
   logic                 dbg_hit;
   logic [NUM_CORES-1:0] pend;
   logic [1:0]           armed [NUM_CORES];
   logic [1:0]           stat  [NUM_CORES];
   logic [NUM_CORES-1:0] ctl_hit;
   logic [31:0]          dbg_q;

   assign wr_acc   = bus_sel && bus_wr;
   assign wake_hit = (bus_addr == ADDR_W'(OFS_WAKE));
   assign dbg_hit  = (bus_addr == ADDR_W'(OFS_DBG));

   for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
      assign ctl_hit[n] = (bus_addr == ADDR_W'(OFS_CTL0 + n * CTL_STRIDE));

      cps_core_seq #(
         .WAKE_CYCLES (WAKE_CYCLES),
         .START_RUN   (n == 0)
      ) i_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .wake_wr  (wr_acc && wake_hit && bus_wdata[n]),
         .ctl_wr   (wr_acc && ctl_hit[n]),
         .ctl_data (bus_wdata[1:0]),
         .wfi      (wfi[n]),
         .pwr_en   (pwr_en[n]),
         .core_rst (core_rst[n]),
         .pend     (pend[n]),
         .armed    (armed[n]),
         .stat     (stat[n])
      );
   end

   cps_dbg_reg #(.WMASK(DBG_WMASK)) i_dbg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_acc && dbg_hit),
      .wdata (bus_wdata),
      .rdata (dbg_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (wake_hit) begin
         bus_rdata[NUM_CORES-1:0] = pend;
      end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
         for (int n = 0; n < NUM_CORES; n++) bus_rdata[4*n +: 2] = stat[n];
      end else if (dbg_hit) begin
         bus_rdata = dbg_q;
      end else begin
         for (int n = 0; n < NUM_CORES; n++)
            if (ctl_hit[n]) bus_rdata[1:0] = armed[n];
      end
   end

   p_unused_wake_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~pwr_en) == '0);
endmodule

// File: tb/test_core_power_seq.sv
`timescale 1ns/1ps
module test_core_power_seq;
   localparam int NC = 4;
   localparam int WC = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] wfi = '0;
   logic [NC-1:0] pwr_en, core_rst;

   int vectors = 0, miscompares = 0;

   always #2.5 clk = ~clk;

   core_power_seq #(.NUM_CORES(NC), .ADDR_W(12), .WAKE_CYCLES(WC)) i_core_power_seq (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wfi(wfi), .pwr_en(pwr_en), .core_rst(core_rst));

   // model: 0 run, 1 standby, 2 powering, 3 releasing
   int m_st[NC], m_cnt[NC], m_pend[NC], m_arm[NC];
   logic [31:0] m_dbg;
   logic [31:0] dbg_mask = 32'h01F8_0000;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < NC; n++) begin
            m_st[n] = (n == 0) ? 0 : 1; m_cnt[n] = 0; m_pend[n] = 0; m_arm[n] = 0;
         end
         m_dbg = 0;
      end else begin
         for (int n = 0; n < NC; n++) begin
            bit ww, cw;
            ww = bus_sel && bus_wr && bus_addr == 12'h010 && bus_wdata[n];
            cw = bus_sel && bus_wr && bus_addr == 12'(256 + 16 * n);
            case (m_st[n])
               0: begin
                  m_pend[n] = ww;
                  if (m_arm[n] == 3 && wfi[n]) begin m_st[n] = 1; m_arm[n] = 0; end
                  else if (cw) m_arm[n] = int'(bus_wdata[1:0]);
               end
               1: begin
                  if (cw) m_arm[n] = int'(bus_wdata[1:0]);
                  if (ww) begin m_st[n] = 2; m_cnt[n] = 0; m_pend[n] = 1; end
               end
               2: begin
                  if (cw) m_arm[n] = int'(bus_wdata[1:0]);
                  if (m_cnt[n] == WC - 1) m_st[n] = 3; else m_cnt[n]++;
               end
               default: begin
                  if (cw) m_arm[n] = int'(bus_wdata[1:0]);
                  m_st[n] = 0; m_pend[n] = 0;
               end
            endcase
         end
         if (bus_sel && bus_wr && bus_addr == 12'h180) m_dbg = bus_wdata & dbg_mask;
      end
   end

   function automatic logic [31:0] model_read(logic [11:0] a);
      logic [31:0] r = '0;
      if (a == 12'h010) for (int n = 0; n < NC; n++) r[n] = m_pend[n][0];
      else if (a == 12'h040) for (int n = 0; n < NC; n++) r[4*n +: 2] = (m_st[n] == 0) ? 2'd0 : 2'd3;
      else if (a == 12'h180) r = m_dbg;
      else for (int n = 0; n < NC; n++) if (a == 12'(256 + 16 * n)) r = 32'(m_arm[n]);
      return r;
   endfunction

   // per-clock comparison of the power outputs
   always @(negedge clk) begin
      if (rst_n) begin
         for (int n = 0; n < NC; n++) begin
            logic ep, er;
            ep = (m_st[n] != 1);
            er = (m_st[n] == 1) || (m_st[n] == 2);
            vectors++;
            if (pwr_en[n] !== ep || core_rst[n] !== er) begin
               miscompares++;
               $display("FAIL R2 R3 R6 R7 core %0d pwr_en/core_rst actual %b%b expected %b%b",
                        n, pwr_en[n], core_rst[n], ep, er);
            end
         end
      end
   end

   task automatic idle(int cycles);
      repeat (cycles) begin
         @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, string tag);
      logic [31:0] exp;
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      exp = model_read(a);
      vectors++;
      if (bus_rdata !== exp) begin
         miscompares++;
         $display("FAIL %s addr %h actual %h expected %h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic pulse_wfi(int n);
      @(negedge clk); bus_sel = 1'b0; wfi[n] = 1'b1;
      @(negedge clk); wfi[n] = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(12'h040, "R1"); rd(12'h010, "R1"); rd(12'h180, "R1");
      vectors++;
      if (bus_rdata !== 32'h0 || pwr_en !== 4'b0001 || core_rst !== 4'b1110) begin
         miscompares++;
         $display("FAIL R1 pwr/rst actual %b/%b expected 0001/1110", pwr_en, core_rst);
      end
      rd(12'h040, "R4");
      vectors++;
      if (bus_rdata !== 32'h0000_3330) begin
         miscompares++;
         $display("FAIL R4 status actual %h expected 00003330", bus_rdata);
      end
      // R2 / R3 wake core 1, poll the wake register every cycle
      wr(12'h010, 32'h0000_0002);
      for (int i = 0; i < WC + 3; i++) rd(12'h010, "R3");
      rd(12'h040, "R4");
      // R8 second wake to core 2 during its power-up, plus bits above NUM_CORES
      wr(12'h010, 32'h0000_00F4);
      rd(12'h010, "R8");
      wr(12'h010, 32'h0000_0004);
      for (int i = 0; i < WC + 2; i++) rd(12'h040, "R3");
      // R5 arm core 1, read back; arming alone keeps it running (R7)
      wr(12'h110, 32'hFFFF_FFF3);
      rd(12'h110, "R5");
      idle(2);
      rd(12'h040, "R7");
      // R6 standby entry on wfi
      pulse_wfi(1);
      rd(12'h040, "R6"); rd(12'h110, "R6");
      // R7 wfi on core 0 with mode 1 is ignored; wfi on sleeping core 3 ignored
      wr(12'h100, 32'h1);
      pulse_wfi(0);
      rd(12'h040, "R7"); rd(12'h100, "R5");
      wr(12'h130, 32'h3);
      pulse_wfi(3);
      rd(12'h040, "R7"); rd(12'h130, "R5");
      // armed while asleep: wake core 3, then wfi drops it (R6)
      wr(12'h010, 32'h8);
      idle(WC + 2);
      rd(12'h040, "R3");
      pulse_wfi(3);
      rd(12'h040, "R6");
      // R8 wake to running core 0: one-cycle bit, no output change
      wr(12'h010, 32'h1);
      rd(12'h010, "R8");
      @(negedge clk); bus_sel = 1'b0;
      rd(12'h010, "R8");
      // R9 debug register mask and undecoded offset
      wr(12'h180, 32'hFFFF_FFFF);
      rd(12'h180, "R9");
      wr(12'h180, 32'h0110_0000);
      rd(12'h180, "R9");
      rd(12'h0F0, "R9");
      // multi-core wake together
      wr(12'h010, 32'h0000_000A);
      for (int i = 0; i < WC + 3; i++) rd(12'h010, "R3");
      rd(12'h040, "R4");
      idle(4);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule